// File: doc/BRIEF.md
# Linked-List DMA Descriptor Sequencer

This block is the control side of a DMA path. Software reaches it through a 32-bit pipelined bus slave. Through that port software sets a local address, a 64-bit host address, a byte count, a next-descriptor pointer and an attribute word, then writes a start command. The sequencer hands these values to the transfer engines, which sit outside the block. It sends them one start pulse, a direction bit and a byte-swap mode.

When an engine reports completion, the sequencer looks at the chain bit of the attribute word. If the bit is set, it asks for the next descriptor from host memory at the next-descriptor pointer. That descriptor arrives as seven 32-bit words, one word per valid cycle. The sequencer loads the words into its working registers and starts the next transfer without software help. If the chain bit is clear, the chain is finished: the block returns to idle and raises its interrupt.

An error pulse from an engine ends the chain at once. A software abort stops it without an interrupt. A status register reports which of these outcomes happened, and any write to that status register clears the interrupt.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After synchronous reset, `irq`, `xfer_start`, `xfer_abort`, `desc_req` and `wb_ack` are 0. Every register reads back 0, and the status code is 0 (idle).
- R2: Each bus request (`wb_cyc` and `wb_stb` high) gets `wb_ack` in the next cycle, with read data in the same cycle. Byte offsets are 0x00 command, 0x04 status, 0x08 local address, 0x0C host low, 0x10 host high, 0x14 length, 0x18 next low, 0x1C next high and 0x20 attributes. While idle, parameter registers read back what was written, except that the attribute register keeps only bits [1:0]. Reading the command offset returns the swap mode in bits [3:2]. Unmapped offsets read 0.
- R3: While idle, writing the command offset with bit 0 set gives a one-cycle `xfer_start` in the cycle after the write is accepted. It also latches `xfer_swap` from bits [3:2] of the written data and sets the status to 1 (busy). `xfer_to_local` equals attribute bit 0, and the address and length outputs equal the registers.
- R4: An `eng_done` pulse while a transfer runs with attribute bit 1 clear returns the block to idle. In the next cycle `irq` is 1 and the status is 0.
- R5: An `eng_done` pulse while attribute bit 1 is set gives a one-cycle `desc_req` in the next cycle, with `desc_addr` = {next high, next low}, and leaves `irq` low. The next seven `desc_valid` words load, in order: local address, host low, host high, length, next low, next high, attributes. `xfer_start` pulses in the cycle after the seventh word and not before.
- R6: An `eng_error` pulse while busy ends the chain in the next cycle, sets the status to 2 and sets `irq`. This holds both during a transfer and during a descriptor fetch. Error takes priority over a simultaneous `eng_done`, and descriptor words that arrive afterwards are ignored.
- R7: Writing the command offset with bit 1 set while busy gives a one-cycle `xfer_abort`, sets the status to 3 and leaves `irq` unchanged. Later done pulses and descriptor words have no effect. The same write while idle gives no `xfer_abort`.
- R8: Any write to the status offset clears `irq` and leaves the status code unchanged.
- R9: While busy, writes to the parameter registers are ignored, and a further start command gives no `xfer_start`.
- R10: While idle, `eng_done`, `eng_error` and `desc_valid` have no effect on `irq`, `xfer_start`, `desc_req` or any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc | input | 1 | Bus cycle |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Bus write enable |
| wb_adr | input | ADR_W | Byte address |
| wb_dat_i | input | 32 | Write data |
| wb_ack | output | 1 | Acknowledge, one cycle after a request |
| wb_dat_o | output | 32 | Read data, valid with `wb_ack` |
| eng_done | input | 1 | Transfer completion pulse from the engines |
| eng_error | input | 1 | Error pulse from the engines |
| desc_valid | input | 1 | A fetched descriptor word is present |
| desc_word | input | 32 | Fetched descriptor word |
| xfer_start | output | 1 | One-cycle transfer start |
| xfer_abort | output | 1 | One-cycle abort |
| xfer_to_local | output | 1 | 1: host to local, 0: local to host |
| xfer_swap | output | 2 | Byte-swap mode |
| xfer_local_addr | output | 32 | Local address |
| xfer_host_addr | output | 64 | Host address |
| xfer_len | output | 32 | Length in bytes |
| desc_req | output | 1 | One-cycle request to fetch a descriptor |
| desc_addr | output | 64 | Host address of the descriptor to fetch |
| irq | output | 1 | Interrupt, held until cleared |

## Verification
The hardest state to reach is an abort or an error that lands in the middle of a descriptor fetch. Some of the seven words are already loaded at that point and the rest are still in flight. The bench gets there by starting a chained transfer, answering the fetch request with only part of the words, and then injecting the abort or the error pulse. It then supplies the remaining words and reads every register back to show that only the words before the event were taken. Random chains of one to four descriptors, with random idle gaps, cover the ordinary hand-over between descriptors.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned OFF_W      = 6;
    localparam int unsigned DESC_WORDS = 7;
    localparam int unsigned IDX_W      = $clog2(DESC_WORDS + 1);

    localparam int unsigned CMD_START_BIT = 0;
    localparam int unsigned CMD_ABORT_BIT = 1;
    localparam int unsigned CMD_SWAP_LSB  = 2;
    localparam int unsigned ATTR_DIR_BIT  = 0;
    localparam int unsigned ATTR_CHAIN_BIT = 1;
    localparam int unsigned ATTR_WORD     = DESC_WORDS - 1;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BUSY    = 2'd1,
        ST_ERROR   = 2'd2,
        ST_ABORTED = 2'd3
    } status_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RUN,
        SQ_FETCH
    } seq_state_e;

    typedef enum logic [3:0] {
        RS_CMD, RS_STATUS, RS_LOCAL, RS_HLO, RS_HHI,
        RS_LEN, RS_NLO, RS_NHI, RS_ATTR, RS_NONE
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        logic              we;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    typedef struct packed {
        logic [DATA_W-1:0]   local_addr;
        logic [2*DATA_W-1:0] host_addr;
        logic [DATA_W-1:0]   len;
        logic [2*DATA_W-1:0] next_ptr;
        logic                chain;
        logic                to_local;
    } xfer_desc_t;

    function automatic reg_sel_e decode_offset(input logic [OFF_W-1:0] off);
        case (off)
            6'h00:   return RS_CMD;
            6'h04:   return RS_STATUS;
            6'h08:   return RS_LOCAL;
            6'h0C:   return RS_HLO;
            6'h10:   return RS_HHI;
            6'h14:   return RS_LEN;
            6'h18:   return RS_NLO;
            6'h1C:   return RS_NHI;
            6'h20:   return RS_ATTR;
            default: return RS_NONE;
        endcase
    endfunction

    // Position of a register in the fetched descriptor; DESC_WORDS means none.
    function automatic logic [IDX_W-1:0] word_index(input reg_sel_e sel);
        case (sel)
            RS_LOCAL: return IDX_W'(0);
            RS_HLO:   return IDX_W'(1);
            RS_HHI:   return IDX_W'(2);
            RS_LEN:   return IDX_W'(3);
            RS_NLO:   return IDX_W'(4);
            RS_NHI:   return IDX_W'(5);
            RS_ATTR:  return IDX_W'(6);
            default:  return IDX_W'(DESC_WORDS);
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] word_mask(input int unsigned idx);
        return (idx == ATTR_WORD) ? DATA_W'(3) : {DATA_W{1'b1}};
    endfunction

endpackage

// File: rtl/dma_chain_bus.sv
module dma_chain_bus
    import dma_chain_pkg::*;
#(
    parameter int unsigned ADR_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wb_cyc,
    input  logic                wb_stb,
    input  logic                wb_we,
    input  logic [ADR_W-1:0]    wb_adr,
    input  logic [DATA_W-1:0]   wb_dat_i,
    input  logic [DATA_W-1:0]   rd_data,
    output bus_req_t            req,
    output logic                wb_ack,
    output logic [DATA_W-1:0]   wb_dat_o
);

    logic addr_hi_ok;

    if (ADR_W > OFF_W) begin : g_hi_bits
        assign addr_hi_ok = ~|wb_adr[ADR_W-1:OFF_W];
    end else begin : g_no_hi_bits
        assign addr_hi_ok = 1'b1;
    end

    always_comb begin
        req.valid = wb_cyc && wb_stb;
        req.we    = wb_we;
        req.sel   = addr_hi_ok ? decode_offset(wb_adr[OFF_W-1:0]) : RS_NONE;
        req.data  = wb_dat_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_ack   <= 1'b0;
            wb_dat_o <= '0;
        end else begin
            wb_ack   <= req.valid;
            wb_dat_o <= (req.valid && !req.we) ? rd_data : '0;
        end
    end

    // R2
    ack_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc && wb_stb) |=> wb_ack);

    // R2
    ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(wb_cyc && wb_stb) |=> !wb_ack);

endmodule

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
    import dma_chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic              busy,
    input  logic              desc_load,
    input  logic [IDX_W-1:0]  desc_idx,
    input  logic [DATA_W-1:0] desc_word,
    input  status_e           status,
    output xfer_desc_t        cur,
    output logic [1:0]        swap,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] words [DESC_WORDS];
    logic              host_wr;
    logic [IDX_W-1:0]  host_idx;
    logic              start_wr;

    assign host_wr  = req.valid && req.we && !busy;
    assign host_idx = word_index(req.sel);
    assign start_wr = host_wr && (req.sel == RS_CMD) && req.data[CMD_START_BIT];

    for (genvar k = 0; k < DESC_WORDS; k++) begin : g_word
        localparam logic [IDX_W-1:0] K_IDX = IDX_W'(k);
        localparam logic [DATA_W-1:0] K_MASK = word_mask(k);

        always_ff @(posedge clk) begin
            if (rst) begin
                words[k] <= '0;
            end else if (host_wr && host_idx == K_IDX) begin
                words[k] <= req.data & K_MASK;
            end else if (desc_load && desc_idx == K_IDX) begin
                words[k] <= desc_word & K_MASK;
            end
        end

        // R9
        param_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (busy && !desc_load) |=> $stable(words[k]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            swap <= 2'b00;
        end else if (start_wr) begin
            swap <= req.data[CMD_SWAP_LSB +: 2];
        end
    end

    always_comb begin
        cur.local_addr = words[0];
        cur.host_addr  = {words[2], words[1]};
        cur.len        = words[3];
        cur.next_ptr   = {words[5], words[4]};
        cur.to_local   = words[ATTR_WORD][ATTR_DIR_BIT];
        cur.chain      = words[ATTR_WORD][ATTR_CHAIN_BIT];
    end

    always_comb begin
        rd_data = '0;
        case (req.sel)
            RS_CMD:    rd_data = {{(DATA_W-4){1'b0}}, swap, 2'b00};
            RS_STATUS: rd_data = {{(DATA_W-2){1'b0}}, status};
            default: begin
                for (int k = 0; k < DESC_WORDS; k++) begin
                    if (host_idx == IDX_W'(k)) rd_data = words[k];
                end
            end
        endcase
    end

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
    import dma_chain_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [1:0]       cmd_bits,
    input  logic             stat_wr,
    input  logic             eng_done,
    input  logic             eng_error,
    input  logic             desc_valid,
    input  logic             chain,
    output logic             busy,
    output logic             desc_load,
    output logic [IDX_W-1:0] desc_idx,
    output logic             xfer_start,
    output logic             xfer_abort,
    output logic             desc_req,
    output status_e          status,
    output logic             irq
);

    seq_state_e state;
    logic       start_cmd;
    logic       abort_cmd;
    logic       last_word;

    assign start_cmd = cmd_wr && cmd_bits[CMD_START_BIT];
    assign abort_cmd = cmd_wr && cmd_bits[CMD_ABORT_BIT];
    assign busy      = (state != SQ_IDLE);
    assign desc_load = (state == SQ_FETCH) && desc_valid;
    assign last_word = (desc_idx == IDX_W'(DESC_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_IDLE;
            status     <= ST_IDLE;
            irq        <= 1'b0;
            xfer_start <= 1'b0;
            xfer_abort <= 1'b0;
            desc_req   <= 1'b0;
            desc_idx   <= '0;
        end else begin
            xfer_start <= 1'b0;
            xfer_abort <= 1'b0;
            desc_req   <= 1'b0;
            if (stat_wr) irq <= 1'b0;

            case (state)
                SQ_IDLE: begin
                    if (start_cmd) begin
                        state      <= SQ_RUN;
                        status     <= ST_BUSY;
                        xfer_start <= 1'b1;
                    end
                end
                default: begin
                    if (abort_cmd) begin
                        state      <= SQ_IDLE;
                        status     <= ST_ABORTED;
                        xfer_abort <= 1'b1;
                        desc_idx   <= '0;
                    end else if (eng_error) begin
                        state    <= SQ_IDLE;
                        status   <= ST_ERROR;
                        irq      <= 1'b1;
                        desc_idx <= '0;
                    end else if (state == SQ_RUN) begin
                        if (eng_done) begin
                            if (chain) begin
                                state    <= SQ_FETCH;
                                desc_req <= 1'b1;
                                desc_idx <= '0;
                            end else begin
                                state  <= SQ_IDLE;
                                status <= ST_IDLE;
                                irq    <= 1'b1;
                            end
                        end
                    end else if (desc_valid) begin
                        if (last_word) begin
                            state      <= SQ_RUN;
                            xfer_start <= 1'b1;
                            desc_idx   <= '0;
                        end else begin
                            desc_idx <= desc_idx + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_start |=> !xfer_start);

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> (status == ST_BUSY));

    // R5
    fetch_gap_chk: assert property (@(posedge clk) disable iff (rst)
        desc_req |=> (!xfer_start && !irq));

    // R6
    error_end_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && eng_error && !abort_cmd) |=> (status == ST_ERROR && irq && !busy));

    // R7
    abort_state_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_abort |-> (status == ST_ABORTED && !busy));

    // R4
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (status != ST_BUSY && status != ST_ABORTED));

endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
    import dma_chain_pkg::*;
#(
    parameter int unsigned ADR_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wb_cyc,
    input  logic                wb_stb,
    input  logic                wb_we,
    input  logic [ADR_W-1:0]    wb_adr,
    input  logic [31:0]         wb_dat_i,
    output logic                wb_ack,
    output logic [31:0]         wb_dat_o,
    input  logic                eng_done,
    input  logic                eng_error,
    input  logic                desc_valid,
    input  logic [31:0]         desc_word,
    output logic                xfer_start,
    output logic                xfer_abort,
    output logic                xfer_to_local,
    output logic [1:0]          xfer_swap,
    output logic [31:0]         xfer_local_addr,
    output logic [63:0]         xfer_host_addr,
    output logic [31:0]         xfer_len,
    output logic                desc_req,
    output logic [63:0]         desc_addr,
    output logic                irq
);

    bus_req_t          req;
    logic [DATA_W-1:0] rd_data;
    logic              busy;
    logic              desc_load;
    logic [IDX_W-1:0]  desc_idx;
    status_e           status;
    xfer_desc_t        cur;
    logic              cmd_wr;
    logic              stat_wr;

    assign cmd_wr  = req.valid && req.we && (req.sel == RS_CMD);
    assign stat_wr = req.valid && req.we && (req.sel == RS_STATUS);

    dma_chain_bus #(.ADR_W(ADR_W)) u_bus (
        .clk      (clk),
        .rst      (rst),
        .wb_cyc   (wb_cyc),
        .wb_stb   (wb_stb),
        .wb_we    (wb_we),
        .wb_adr   (wb_adr),
        .wb_dat_i (wb_dat_i),
        .rd_data  (rd_data),
        .req      (req),
        .wb_ack   (wb_ack),
        .wb_dat_o (wb_dat_o)
    );

    dma_chain_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .busy      (busy),
        .desc_load (desc_load),
        .desc_idx  (desc_idx),
        .desc_word (desc_word),
        .status    (status),
        .cur       (cur),
        .swap      (xfer_swap),
        .rd_data   (rd_data)
    );

    dma_chain_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_wr     (cmd_wr),
        .cmd_bits   (req.data[1:0]),
        .stat_wr    (stat_wr),
        .eng_done   (eng_done),
        .eng_error  (eng_error),
        .desc_valid (desc_valid),
        .chain      (cur.chain),
        .busy       (busy),
        .desc_load  (desc_load),
        .desc_idx   (desc_idx),
        .xfer_start (xfer_start),
        .xfer_abort (xfer_abort),
        .desc_req   (desc_req),
        .status     (status),
        .irq        (irq)
    );

    assign xfer_to_local   = cur.to_local;
    assign xfer_local_addr = cur.local_addr;
    assign xfer_host_addr  = cur.host_addr;
    assign xfer_len        = cur.len;
    assign desc_addr       = cur.next_ptr;

endmodule

// File: tb/tb_dma_chain_ctrl.sv
module tb_dma_chain_ctrl;

    localparam time CLK_PERIOD = 10ns;
    localparam int  ADR_W = 6;
    localparam int  WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wb_cyc = 0, wb_stb = 0, wb_we = 0;
    logic [ADR_W-1:0] wb_adr = '0;
    logic [31:0] wb_dat_i = '0;
    logic        wb_ack;
    logic [31:0] wb_dat_o;
    logic        eng_done = 0, eng_error = 0, desc_valid = 0;
    logic [31:0] desc_word = '0;
    logic        xfer_start, xfer_abort, xfer_to_local, desc_req, irq;
    logic [1:0]  xfer_swap;
    logic [31:0] xfer_local_addr, xfer_len;
    logic [63:0] xfer_host_addr, desc_addr;

    dma_chain_ctrl #(.ADR_W(ADR_W)) dut (
        .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
        .wb_adr(wb_adr), .wb_dat_i(wb_dat_i), .wb_ack(wb_ack), .wb_dat_o(wb_dat_o),
        .eng_done(eng_done), .eng_error(eng_error), .desc_valid(desc_valid),
        .desc_word(desc_word), .xfer_start(xfer_start), .xfer_abort(xfer_abort),
        .xfer_to_local(xfer_to_local), .xfer_swap(xfer_swap),
        .xfer_local_addr(xfer_local_addr), .xfer_host_addr(xfer_host_addr),
        .xfer_len(xfer_len), .desc_req(desc_req), .desc_addr(desc_addr), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  all_done = 0;

    // model state
    logic [31:0] m_w [7];
    logic [1:0]  m_swap = 0;
    logic [1:0]  m_status = 0;

    // observations
    logic [31:0] obs_rd;
    logic        obs_start, obs_abort, obs_req;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_of(input int k);
        return (k == 6) ? 32'h3 : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [5:0] off_of(input int k);
        return 6'(8 + 4 * k);
    endfunction

    task automatic bus(input logic we, input logic [5:0] off, input logic [31:0] d);
        @(negedge clk);
        wb_cyc = 1; wb_stb = 1; wb_we = we; wb_adr = off; wb_dat_i = d;
        @(negedge clk);
        check("R2 ack after request", wb_ack, 1);
        obs_rd = wb_dat_o; obs_start = xfer_start; obs_abort = xfer_abort; obs_req = desc_req;
        wb_cyc = 0; wb_stb = 0; wb_we = 0;
    endtask

    task automatic pulse(input logic d, input logic e);
        @(negedge clk);
        eng_done = d; eng_error = e;
        @(negedge clk);
        eng_done = 0; eng_error = 0;
        obs_start = xfer_start; obs_abort = xfer_abort; obs_req = desc_req;
    endtask

    task automatic feed(input logic [31:0] v);
        @(negedge clk);
        desc_valid = 1; desc_word = v;
        @(negedge clk);
        desc_valid = 0;
        obs_start = xfer_start; obs_req = desc_req;
    endtask

    task automatic readback(input string tag);
        for (int k = 0; k < 7; k++) begin
            bus(0, off_of(k), 0);
            check({tag, " register readback"}, obs_rd, m_w[k]);
        end
        bus(0, 6'h04, 0);
        check({tag, " status readback"}, obs_rd, {30'd0, m_status});
        bus(0, 6'h00, 0);
        check({tag, " command readback"}, obs_rd, {28'd0, m_swap, 2'b00});
        bus(0, 6'h24, 0);
        check("R2 unmapped reads zero", obs_rd, 0);
    endtask

    task automatic check_outputs(input string tag);
        check({tag, " local addr"}, xfer_local_addr, m_w[0]);
        check({tag, " host addr"}, xfer_host_addr, {m_w[2], m_w[1]});
        check({tag, " length"}, xfer_len, m_w[3]);
        check({tag, " direction"}, xfer_to_local, m_w[6][0]);
        check({tag, " swap"}, xfer_swap, m_swap);
    endtask

    task automatic program_regs(input logic chain_bit);
        for (int k = 0; k < 7; k++) begin
            logic [31:0] v;
            v = $urandom;
            if (k == 6) v = {30'd0, chain_bit, v[0]};
            bus(1, off_of(k), v);
            m_w[k] = v & mask_of(k);
        end
    endtask

    task automatic start_xfer(input logic [1:0] sw);
        bus(1, 6'h00, {28'd0, sw, 2'b01});
        m_swap = sw; m_status = 1;
        check("R3 start pulse", obs_start, 1);
        check_outputs("R3");
        @(negedge clk);
        check("R3 start is one cycle", xfer_start, 0);
    endtask

    task automatic run_chain(input int nchain);
        program_regs(nchain > 1);
        readback("R2");
        start_xfer(2'($urandom));
        begin
            int k;
            logic [31:0] old;
            k = $urandom % 7;
            old = m_w[k];
            bus(1, off_of(k), $urandom);
            bus(0, off_of(k), 0);
            check("R9 busy write ignored", obs_rd, old);
            bus(1, 6'h00, 32'h1);
            check("R9 no restart while busy", obs_start, 0);
            bus(0, 6'h04, 0);
            check("R3 status busy", obs_rd, 1);
        end
        for (int c = 0; c < nchain; c++) begin
            repeat ($urandom % 4) @(negedge clk);
            pulse(1, 0);
            if (m_w[6][1]) begin
                check("R5 descriptor request", obs_req, 1);
                check("R5 descriptor address", desc_addr, {m_w[5], m_w[4]});
                check("R5 no irq mid-chain", irq, 0);
                for (int j = 0; j < 7; j++) begin
                    logic [31:0] v;
                    v = $urandom;
                    if (j == 6) v = {30'd0, (c + 2 < nchain), v[0]};
                    if (j > 0 && ($urandom % 3 == 0)) @(negedge clk);
                    feed(v);
                    m_w[j] = v & mask_of(j);
                    check(j == 6 ? "R5 start after last word" : "R5 no early start",
                          obs_start, (j == 6));
                end
                check_outputs("R5");
            end else begin
                m_status = 0;
                check("R4 irq on completion", irq, 1);
                check("R4 no descriptor request", obs_req, 0);
                bus(0, 6'h04, 0);
                check("R4 status idle", obs_rd, 0);
            end
        end
        bus(1, 6'h04, $urandom);
        @(negedge clk);
        check("R8 irq cleared", irq, 0);
        bus(0, 6'h04, 0);
        check("R8 status kept", obs_rd, {30'd0, m_status});
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!all_done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int k = 0; k < 7; k++) m_w[k] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", irq, 0);
        check("R1 start", xfer_start, 0);
        check("R1 abort", xfer_abort, 0);
        check("R1 request", desc_req, 0);
        check("R1 ack", wb_ack, 0);
        readback("R1");

        // R10 stray inputs while idle
        pulse(1, 0);
        check("R10 done ignored irq", irq, 0);
        check("R10 done ignored req", obs_req, 0);
        pulse(0, 1);
        check("R10 error ignored irq", irq, 0);
        feed(32'hDEAD_BEEF);
        check("R10 word ignored start", obs_start, 0);
        readback("R10");

        // random chains
        for (int it = 0; it < 30; it++) run_chain(1 + ($urandom % 4));

        // R6 error beats done on a chained transfer
        program_regs(1);
        start_xfer(2'd2);
        pulse(1, 1);
        m_status = 2;
        check("R6 no fetch on error", obs_req, 0);
        check("R6 irq on error", irq, 1);
        bus(0, 6'h04, 0);
        check("R6 error status", obs_rd, 2);
        pulse(1, 0);
        check("R10 done after error ignored", obs_req, 0);
        bus(1, 6'h04, 0);
        @(negedge clk);
        check("R8 irq cleared after error", irq, 0);
        bus(0, 6'h04, 0);
        check("R8 error status kept", obs_rd, 2);

        // R6 error during fetch
        program_regs(1);
        start_xfer(2'd1);
        pulse(1, 0);
        check("R5 request before error", obs_req, 1);
        for (int j = 0; j < 3; j++) begin
            logic [31:0] v;
            v = $urandom;
            feed(v);
            m_w[j] = v;
        end
        pulse(0, 1);
        m_status = 2;
        check("R6 irq in fetch", irq, 1);
        for (int j = 3; j < 7; j++) begin
            feed($urandom);
            check("R6 late word no start", obs_start, 0);
        end
        readback("R6");
        bus(1, 6'h04, 0);

        // R7 abort while running
        program_regs(0);
        start_xfer(2'd3);
        bus(1, 6'h00, 32'h2);
        m_status = 3;
        check("R7 abort pulse", obs_abort, 1);
        check("R7 no irq", irq, 0);
        @(negedge clk);
        check("R7 abort one cycle", xfer_abort, 0);
        pulse(1, 0);
        check("R7 done after abort no irq", irq, 0);
        bus(0, 6'h04, 0);
        check("R7 aborted status", obs_rd, 3);

        // R7 abort during fetch
        program_regs(1);
        start_xfer(2'd0);
        pulse(1, 0);
        for (int j = 0; j < 2; j++) begin
            logic [31:0] v;
            v = $urandom;
            feed(v);
            m_w[j] = v;
        end
        bus(1, 6'h00, 32'h2);
        m_status = 3;
        check("R7 abort in fetch", obs_abort, 1);
        for (int j = 2; j < 7; j++) begin
            feed($urandom);
            check("R7 late word no start", obs_start, 0);
        end
        check("R7 no irq after fetch abort", irq, 0);
        readback("R7");

        // R7 abort while idle does nothing
        bus(1, 6'h00, 32'h2);
        check("R7 idle abort ignored", obs_abort, 0);

        all_done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule